// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block starts a serial fronthaul link core after the device is configured. A start request makes it pulse every core reset line together for a set number of cycles. It then issues one register write on a simple memory-mapped master port, which tells the core to begin sending K28.5 comma characters. After that it reads the core's packed receive status word in stages. It reports the link as ready once the receiver holds frame sync and both frame counters, hyperframe and basic frame, report that they are initialized.

Each stage that waits on something outside the block has a cycle budget. If the budget runs out, the block flags an error and starts the whole sequence again from the reset pulse. The status word comes from another clock domain, so it passes through two flops before any field is decoded. If sync is lost while the link is ready, the block drops ready and goes back to waiting for frame sync.

Top module: `link_bringup`

## Requirements
- R1: Every core reset output (config, cpu, main, delay, and each mapper receive and transmit line) is high in the reset phase and low in all other phases.
- R2: When start is sampled high in the idle phase, the reset phase begins. It lasts exactly max(RST_HOLD, 3) cycles, then the config write phase follows.
- R3: In the config write phase, busWrite is high with busAddr = 0x8 and busWrData = 0x21. These hold stable while busWaitReq is high. busWrite is low from the cycle after the write is accepted with busWaitReq low.
- R4: The status word passes through two flop stages. A change on statusWord reaches the decode logic two clock edges later.
- R5: In the wait-sync phase, the block moves on only when status bits [1:0] = 3 and bits [4:2] = 1. A sync state of 2, or a sync state of 3 with any other counter value, keeps it waiting.
- R6: In the wait-hyperframe phase, only status bit 7 = 1 moves it on. Bit 6 alone has no effect in this phase.
- R7: In the wait-basic-frame phase, status bit 6 = 1 moves it to the ready phase, and ready is high there.
- R8: The config write, wait-sync, wait-hyperframe and wait-basic-frame phases each last at most TIMEOUT cycles. On expiry the block spends one cycle in the error phase with error high and ready low, then re-enters the reset phase. If the awaited condition is met in the last allowed cycle, the block advances instead of timing out.
- R9: In the ready phase, a sync state other than 3 in bits [1:0] clears ready and returns the block to the wait-sync phase.
- R10: The phase output encodes idle=0, reset=1, config write=2, wait sync=3, wait hyperframe=4, wait basic frame=5, ready=6, error=7. After reset it reads idle, with ready, error, busWrite and all core resets low.
- R11: error stays high from a timeout until the ready phase is next reached, and it clears there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| startReq | input | 1 | Starts the bring-up when sampled in the idle phase |
| statusWord | input | STAT_W | Packed receive status from the link core, not yet synchronized |
| busWaitReq | input | 1 | Slave stall; a write is accepted when this is low |
| cfgRst | output | 1 | Core configuration reset |
| cpuRst | output | 1 | Core register-interface reset |
| mainRst | output | 1 | Core main reset |
| delayRst | output | 1 | Core delay-measurement reset |
| mapRxRst | output | NUM_MAP | Per-channel mapper receive resets |
| mapTxRst | output | NUM_MAP | Per-channel mapper transmit resets |
| busAddr | output | ADDR_W | Write address |
| busWrData | output | DATA_W | Write data |
| busWrite | output | 1 | Write strobe |
| ready | output | 1 | Link is up |
| error | output | 1 | A wait phase timed out since the last ready |
| phase | output | 3 | Current sequencer phase |

## Verification
Two things can fall on the same cycle: the awaited status condition arriving, and the phase timeout expiring. The bench provokes this in the wait-sync phase. It drives the sync pattern at a chosen count of cycles after the phase is entered, so that, after the two synchronizer stages, the decoded sync lands exactly on the last allowed cycle. It then checks that the block advances to the wait-hyperframe phase. It repeats the run with the pattern one cycle later and checks that the error phase follows. Together the two runs pin down both the synchronizer latency and the priority of success over timeout.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RESET = 3'd1,
    PH_CFGWR = 3'd2,
    PH_WSYNC = 3'd3,
    PH_WHFN  = 3'd4,
    PH_WBFN  = 3'd5,
    PH_READY = 3'd6,
    PH_ERROR = 3'd7
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic errSet;
    logic errClr;
  } ctrl_strb_t;

  // Decoded conditions from datapath to control
  typedef struct packed {
    logic holdDone;
    logic timeUp;
    logic syncOk;
    logic hfnOk;
    logic bfnOk;
    logic syncLost;
  } dp_flags_t;

  // Status field positions decoded by the sequencer
  localparam int ST_STATE_LO = 0;
  localparam int ST_CNT_LO   = 2;
  localparam int ST_BFN_BIT  = 6;
  localparam int ST_HFN_BIT  = 7;

endpackage

// File: rtl/link_bringup_dp.sv
module link_bringup_dp
  import link_bringup_pkg::*;
#(
  parameter int HOLD_CYC    = 3,
  parameter int TIMEOUT_CYC = 1000,
  parameter int STAT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  input  ctrl_strb_t        strb,
  output dp_flags_t         flags,
  output logic              errFlag
);

  localparam int MAXC  = (TIMEOUT_CYC > HOLD_CYC) ? TIMEOUT_CYC : HOLD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0]  cnt;
  logic [STAT_W-1:0] syncA, syncB;

  // Phase cycle counter, cleared on each phase change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.cntClr)             cnt <= '0;
    else if (cnt != CNT_W'(MAXC))     cnt <= cnt + CNT_W'(1);
  end

  // Two-stage status synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= statusIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             errFlag <= 1'b0;
    else if (strb.errSet)  errFlag <= 1'b1;
    else if (strb.errClr)  errFlag <= 1'b0;
  end

  always_comb begin
    flags.holdDone = (cnt >= CNT_W'(HOLD_CYC - 1));
    flags.timeUp   = (cnt >= CNT_W'(TIMEOUT_CYC - 1));
    flags.syncOk   = (syncB[ST_STATE_LO +: 2] == 2'd3) && (syncB[ST_CNT_LO +: 3] == 3'd1);
    flags.hfnOk    = syncB[ST_HFN_BIT];
    flags.bfnOk    = syncB[ST_BFN_BIT];
    flags.syncLost = (syncB[ST_STATE_LO +: 2] != 2'd3);
  end

  // Assertion support: edges seen since reset release
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  // R4: decode input lags the port by two edges
  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (syncB == $past(statusIn, 2)));

  // R11: error only rises on a timeout strobe
  p_err_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strb.errSet));

endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
  import link_bringup_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int unsigned CFG_ADDR = 32'h8,
  parameter int unsigned CFG_DATA = 32'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              busWaitReq,
  input  dp_flags_t         flags,
  output ctrl_strb_t        strb,
  output logic [2:0]        phase,
  output logic              rstAll,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              ready
);

  phase_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE:  if (startReq)        nextState = PH_RESET;
      PH_RESET: if (flags.holdDone)  nextState = PH_CFGWR;
      PH_CFGWR: if (!busWaitReq)     nextState = PH_WSYNC;
                else if (flags.timeUp) nextState = PH_ERROR;
      PH_WSYNC: if (flags.syncOk)    nextState = PH_WHFN;
                else if (flags.timeUp) nextState = PH_ERROR;
      PH_WHFN:  if (flags.hfnOk)     nextState = PH_WBFN;
                else if (flags.timeUp) nextState = PH_ERROR;
      PH_WBFN:  if (flags.bfnOk)     nextState = PH_READY;
                else if (flags.timeUp) nextState = PH_ERROR;
      PH_READY: if (flags.syncLost)  nextState = PH_WSYNC;
      PH_ERROR:                      nextState = PH_RESET;
      default:                       nextState = PH_IDLE;
    endcase
  end

  always_comb begin
    strb.cntClr = (nextState != state);
    strb.errSet = (nextState == PH_ERROR) && (state != PH_ERROR);
    strb.errClr = (nextState == PH_READY) && (state != PH_READY);
  end

  assign phase     = state;
  assign rstAll    = (state == PH_RESET);
  assign busWrite  = (state == PH_CFGWR);
  assign busAddr   = busWrite ? ADDR_W'(CFG_ADDR) : '0;
  assign busWrData = busWrite ? DATA_W'(CFG_DATA) : '0;
  assign ready     = (state == PH_READY);

  // R2: reset pulse ends only after the hold count
  p_rst_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstAll) |-> $past(flags.holdDone));

  // R3: stalled write keeps its fields
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busWaitReq) |=> (busWrite && $stable(busAddr) && $stable(busWrData)));

  // R3: strobe drops after acceptance
  p_bus_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busWaitReq) |=> !busWrite);

  // R5: frame sync gate
  p_sync_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WHFN && $past(state) == PH_WSYNC) |-> $past(flags.syncOk));

  // R6: hyperframe gate
  p_hfn_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WBFN && $past(state) == PH_WHFN) |-> $past(flags.hfnOk));

  // R7: ready only after basic-frame flag
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(flags.bfnOk));

  // R8: error phase is one cycle then restart
  p_err_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ERROR) |=> (state == PH_RESET));

  // R9: sync loss while ready
  p_sync_loss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && flags.syncLost) |=> (!ready && state == PH_WSYNC));

endmodule

// File: rtl/link_bringup.sv
module link_bringup #(
  parameter int          NUM_MAP  = 2,
  parameter int          STAT_W   = 8,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          RST_HOLD = 4,
  parameter int          TIMEOUT  = 1000,
  parameter int unsigned CFG_ADDR = 32'h8,
  parameter int unsigned CFG_DATA = 32'h21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [STAT_W-1:0]  statusWord,
  input  logic               busWaitReq,
  output logic               cfgRst,
  output logic               cpuRst,
  output logic               mainRst,
  output logic               delayRst,
  output logic [NUM_MAP-1:0] mapRxRst,
  output logic [NUM_MAP-1:0] mapTxRst,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWrData,
  output logic               busWrite,
  output logic               ready,
  output logic               error,
  output logic [2:0]         phase
);
  import link_bringup_pkg::*;

  localparam int HOLD_EFF = (RST_HOLD < 3) ? 3 : RST_HOLD;

  ctrl_strb_t strb;
  dp_flags_t  flags;
  logic       rstAll;

  link_bringup_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR), .CFG_DATA(CFG_DATA)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busWaitReq(busWaitReq),
    .flags(flags), .strb(strb), .phase(phase), .rstAll(rstAll),
    .busWrite(busWrite), .busAddr(busAddr), .busWrData(busWrData), .ready(ready)
  );

  link_bringup_dp #(
    .HOLD_CYC(HOLD_EFF), .TIMEOUT_CYC(TIMEOUT), .STAT_W(STAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .statusIn(statusWord), .strb(strb),
    .flags(flags), .errFlag(error)
  );

  assign cfgRst   = rstAll;
  assign cpuRst   = rstAll;
  assign mainRst  = rstAll;
  assign delayRst = rstAll;
  assign mapRxRst = {NUM_MAP{rstAll}};
  assign mapTxRst = {NUM_MAP{rstAll}};

endmodule

// File: tb/link_bringup_tb.sv
module link_bringup_tb;
  localparam int NM   = 2;
  localparam int HOLD = 5;
  localparam int TMO  = 20;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, busWaitReq = 1'b0;
  logic [7:0] statusWord = '0;
  logic cfgRst, cpuRst, mainRst, delayRst, busWrite, ready, error;
  logic [NM-1:0] mapRxRst, mapTxRst;
  logic [7:0] busAddr;
  logic [31:0] busWrData;
  logic [2:0] phase;
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  link_bringup #(.NUM_MAP(NM), .RST_HOLD(HOLD), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .statusWord(statusWord),
    .busWaitReq(busWaitReq), .cfgRst(cfgRst), .cpuRst(cpuRst), .mainRst(mainRst),
    .delayRst(delayRst), .mapRxRst(mapRxRst), .mapTxRst(mapTxRst),
    .busAddr(busAddr), .busWrData(busWrData), .busWrite(busWrite),
    .ready(ready), .error(error), .phase(phase));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit rstAllHigh();
    return cfgRst && cpuRst && mainRst && delayRst && (&mapRxRst) && (&mapTxRst);
  endfunction
  function automatic bit rstAllLow();
    return !cfgRst && !cpuRst && !mainRst && !delayRst && !(|mapRxRst) && !(|mapTxRst);
  endfunction

  task automatic waitPh(input logic [2:0] p, input int maxCyc, input string req);
    for (int i = 0; i < maxCyc; i++) begin
      if (phase == p) break;
      @(negedge clk);
    end
    chk(phase == p, req, phase, p);
  endtask

  task automatic restart();
    @(negedge clk);
    rstN = 1'b0; statusWord = '0; startReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic testReset();
    chk(phase == 3'd0 && !ready && !error && !busWrite, "R10 reset state", phase, 0);
    chk(rstAllLow(), "R1 resets low in idle", cfgRst, 0);
  endtask

  task automatic testBringup();
    int len;
    busWaitReq = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    len = 0;
    chk(phase == 3'd1, "R10 reset phase code", phase, 1);
    while (cfgRst && len < 50) begin
      chk(rstAllHigh(), "R1 resets asserted together", mainRst, 1);
      len++;
      @(negedge clk);
    end
    chk(len == HOLD, "R2 reset hold length", len, HOLD);
    chk(rstAllLow(), "R1 resets released together", cfgRst, 0);
    for (int i = 0; i < 3; i++) begin
      chk(busWrite && phase == 3'd2, "R3 write held while stalled", busWrite, 1);
      chk(busAddr == 8'h08 && busWrData == 32'h21, "R3 write fields", busWrData, 'h21);
      @(negedge clk);
    end
    busWaitReq = 1'b0;
    @(negedge clk);
    chk(!busWrite && phase == 3'd3, "R3 strobe dropped after accept", phase, 3);
    statusWord = 8'h02;
    repeat (5) @(negedge clk);
    chk(phase == 3'd3, "R5 state 2 keeps waiting", phase, 3);
    statusWord = 8'h0B;
    repeat (5) @(negedge clk);
    chk(phase == 3'd3, "R5 wrong sync counter keeps waiting", phase, 3);
    statusWord = 8'h07;
    waitPh(3'd4, 5, "R5 frame sync reached");
    statusWord = 8'h47;
    repeat (5) @(negedge clk);
    chk(phase == 3'd4, "R6 bit6 alone ignored in hyperframe wait", phase, 4);
    statusWord = 8'hC7;
    waitPh(3'd6, 6, "R7 ready phase reached");
    chk(ready && !error, "R7 ready high", ready, 1);
  endtask

  task automatic testLoss();
    statusWord = 8'hC5;
    repeat (3) @(negedge clk);
    chk(phase == 3'd3 && !ready, "R9 sync loss returns to wait sync", phase, 3);
    statusWord = 8'hC7;
    waitPh(3'd6, 8, "R9 ready regained");
  endtask

  task automatic testTimeout();
    busWaitReq = 1'b0;
    restart();
    waitPh(3'd3, 20, "R8 reach wait sync");
    repeat (TMO) @(negedge clk);
    chk(phase == 3'd7 && error && !ready, "R8 timeout enters error", phase, 7);
    @(negedge clk);
    chk(phase == 3'd1, "R8 restart from reset phase", phase, 1);
    chk(error, "R11 error held through restart", error, 1);
    statusWord = 8'hC7;
    waitPh(3'd6, 100, "R11 bring-up after error");
    chk(!error, "R11 error cleared at ready", error, 0);
  endtask

  task automatic testRace(input int drvAt, input logic [2:0] expPh, input string req);
    busWaitReq = 1'b0;
    restart();
    waitPh(3'd3, 20, "R8 reach wait sync");
    for (int n = 0; n < TMO; n++) begin
      if (n == drvAt) statusWord = 8'h07;
      @(negedge clk);
    end
    chk(phase == expPh, req, phase, expPh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChk + 1, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBringup();
    testLoss();
    testTimeout();
    testRace(TMO - 3, 3'd4, "R4 R8 sync on last cycle wins");
    testRace(TMO - 2, 3'd7, "R4 R8 sync one cycle late times out");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule